// File: doc/BRIEF.md
# Paged Serial Memory Controller

This block is the memory side of a byte-level serial slave that fronts a nonvolatile byte array. A separate bit-level engine handles the wire protocol and passes events to this block: start and stop conditions, a header event when the device address byte matches, bytes received from the master, requests for bytes to send, and the master's NAK at the end of a read. For every header, every received byte and every refused read request, the block answers with an ACK or NAK decision. While a page is being programmed it can also hold the bus with a clock-stretch request.

A transfer opens with a write-direction header. The first two data bytes that follow load a 16-bit pointer, high byte first. Any further data bytes are written at the pointer, and the pointer advances after each one. Writes collect in a page buffer whose pages are aligned on PAGE_BYTES boundaries. The buffer is committed to the array by a program cycle that lasts PROG_LAT clocks. A commit starts in either of two cases: a byte is stored at the last offset of a page, or a start or stop condition arrives while the buffer holds data.

To read, the master sends a read-direction header, either after a repeated start or in a later transaction. Each byte sent advances the pointer. The received-byte input is a valid/ready stream: the block lowers `wr_ready` only while a page program is running in the write-data phase. The read side is also a valid/ready stream: `rd_valid` stays high while the pointer is inside the array, and the engine takes a byte by raising `rd_ready`. Both streams may hold their valid or ready high across cycles. A byte moves on each cycle in which valid and ready are both high.

Top module: `memc_ser_mem`

## Requirements
- R1: After reset, `resp_valid`, `stretch` and `rd_valid` are 0 and `wr_ready` is 1.
- R2: A write header (`hdr_rw`=0) is answered with ACK (`resp_ack`=1). The next two accepted bytes load pointer bits 15:8 and then 7:0, and each is answered with ACK.
- R3: A read header (`hdr_rw`=1) whose pointer is within the array is answered with ACK. Each read transfer presents the array byte at the pointer on `rd_data`, and the pointer then increases by one.
- R4: The pointer keeps its value across a repeated start and across a stop, so a later read with no address phase continues from it.
- R5: A data byte in the write phase is stored at the pointer, and the pointer advances. If the pointer is above MEM_BYTES-1 (this includes any set bit above the array width), the byte gets a NAK, nothing is stored and the pointer stays where it is.
- R6: A read header with the pointer above MEM_BYTES-1 gets a NAK. In the read phase, `rd_valid` is low when the pointer is past the top, and a `rd_ready` given then is answered with a NAK.
- R7: Storing a byte at page offset PAGE_BYTES-1 starts a program cycle. For exactly PROG_LAT cycles `wr_ready` is 0 and `stretch` is 1. The held byte is then accepted and gets an ACK.
- R8: A start or stop with buffered bytes starts a program cycle of PROG_LAT cycles. A header that arrives during it gets a NAK, and every byte of that transaction then gets a NAK.
- R9: A master NAK (`rd_nak_in`) ends the read phase: `rd_valid` drops on the next cycle, and the pointer addresses the byte after the last one sent.
- R10: `resp_valid` pulses for one cycle, exactly one cycle after each header, each accepted byte, and each refused read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_start | input | 1 | Start or repeated-start pulse |
| bus_stop | input | 1 | Stop pulse |
| hdr_valid | input | 1 | Matching address header pulse |
| hdr_rw | input | 1 | Header direction, 1 = read |
| wr_valid | input | 1 | Received byte valid |
| wr_ready | output | 1 | Received byte accepted this cycle when valid |
| wr_data | input | 8 | Received byte |
| rd_valid | output | 1 | Byte available to send |
| rd_ready | input | 1 | Engine takes the byte |
| rd_data | output | 8 | Byte to send |
| rd_nak_in | input | 1 | Master NAK pulse ending a read |
| resp_valid | output | 1 | Decision pulse |
| resp_ack | output | 1 | Decision, 1 = ACK, 0 = NAK |
| stretch | output | 1 | Clock-stretch request |

## Verification
Two things can land on the same clock edge. The byte at the last page offset is stored, which launches a program cycle, and on that same edge the next byte is already waiting on the stream. The bench keeps `wr_valid` high without a break through a page crossing. It then counts the cycles in which the waiting byte is held with `stretch` set, and requires exactly PROG_LAT of them followed by an ACK. A second case puts a stop with a part-filled buffer right before a new header, which must draw a NAK because the program cycle is still running.

// File: rtl/memc_pkg.sv
package memc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_AHI,
    ST_ALO,
    ST_WDAT,
    ST_RDAT,
    ST_DEAD
  } memc_state_e;
endpackage

// File: rtl/memc_page.sv
module memc_page #(
  parameter int MEM_BYTES  = 1024,
  parameter int PAGE_BYTES = 64,
  parameter int PROG_LAT   = 200
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         st_en,
  input  logic [$clog2(MEM_BYTES)-1:0] st_addr,
  input  logic [7:0]                   st_data,
  input  logic                         launch,
  input  logic [$clog2(MEM_BYTES)-1:0] rd_addr,
  output logic [7:0]                   rd_data,
  output logic                         busy
);
  localparam int AW = $clog2(MEM_BYTES);
  localparam int PW = $clog2(PAGE_BYTES);
  localparam int BW = AW - PW;
  localparam int CW = $clog2(PROG_LAT + 1);

  logic [7:0]            mem  [MEM_BYTES];
  logic [7:0]            pbuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] mask_q;
  logic [BW-1:0]         base_q;
  logic [CW-1:0]         cnt_q;
  logic                  busy_q;
  logic                  dirty;
  logic                  finish;

  assign dirty   = (|mask_q) || st_en;
  assign finish  = busy_q && (cnt_q == '0);
  assign busy    = busy_q;
  assign rd_data = mem[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      base_q <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      if (st_en) begin
        mask_q[st_addr[PW-1:0]] <= 1'b1;
        base_q <= st_addr[AW-1:PW];
      end
      if (launch && dirty && !busy_q) begin
        busy_q <= 1'b1;
        cnt_q  <= CW'(PROG_LAT - 1);
      end else if (finish) begin
        busy_q <= 1'b0;
        mask_q <= '0;
      end else if (busy_q) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (st_en) pbuf[st_addr[PW-1:0]] <= st_data;
    if (finish) begin
      for (int i = 0; i < PAGE_BYTES; i++) begin
        if (mask_q[i]) mem[{base_q, PW'(i)}] <= pbuf[i];
      end
    end
  end
endmodule

// File: rtl/memc_ctrl.sv
module memc_ctrl
  import memc_pkg::*;
#(
  parameter int MEM_BYTES  = 1024,
  parameter int PAGE_BYTES = 64
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         bus_start,
  input  logic                         bus_stop,
  input  logic                         hdr_valid,
  input  logic                         hdr_rw,
  input  logic                         wr_valid,
  output logic                         wr_ready,
  input  logic [7:0]                   wr_data,
  output logic                         rd_valid,
  input  logic                         rd_ready,
  input  logic                         rd_nak_in,
  output logic                         resp_valid,
  output logic                         resp_ack,
  output logic                         stretch,
  input  logic                         busy,
  output logic                         st_en,
  output logic [$clog2(MEM_BYTES)-1:0] st_addr,
  output logic                         launch,
  output logic [$clog2(MEM_BYTES)-1:0] rd_addr
);
  localparam int AW = $clog2(MEM_BYTES);
  localparam int PW = $clog2(PAGE_BYTES);
  localparam logic [15:0] TOP = 16'(MEM_BYTES - 1);

  memc_state_e state_q;
  logic [15:0] ptr_q;
  logic        in_range;
  logic        wr_fire;
  logic        rd_fire;

  assign in_range = (ptr_q <= TOP);
  assign wr_ready = !((state_q == ST_WDAT) && busy);
  assign stretch  = (state_q == ST_WDAT) && busy;
  assign wr_fire  = wr_valid && wr_ready;
  assign rd_valid = (state_q == ST_RDAT) && in_range;
  assign rd_fire  = rd_valid && rd_ready;
  assign st_en    = wr_fire && (state_q == ST_WDAT) && in_range;
  assign st_addr  = ptr_q[AW-1:0];
  assign rd_addr  = ptr_q[AW-1:0];
  assign launch   = (st_en && (&ptr_q[PW-1:0])) || bus_start || bus_stop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      ptr_q      <= '0;
      resp_valid <= 1'b0;
      resp_ack   <= 1'b0;
    end else begin
      resp_valid <= 1'b0;
      if (bus_start || bus_stop) begin
        state_q <= ST_IDLE;
      end else if (hdr_valid) begin
        resp_valid <= 1'b1;
        if (busy || state_q != ST_IDLE) begin
          resp_ack <= 1'b0;
          state_q  <= ST_DEAD;
        end else if (!hdr_rw) begin
          resp_ack <= 1'b1;
          state_q  <= ST_AHI;
        end else begin
          resp_ack <= in_range;
          state_q  <= in_range ? ST_RDAT : ST_DEAD;
        end
      end else if (wr_fire) begin
        resp_valid <= 1'b1;
        case (state_q)
          ST_AHI: begin
            ptr_q[15:8] <= wr_data;
            resp_ack    <= 1'b1;
            state_q     <= ST_ALO;
          end
          ST_ALO: begin
            ptr_q[7:0] <= wr_data;
            resp_ack   <= 1'b1;
            state_q    <= ST_WDAT;
          end
          ST_WDAT: begin
            resp_ack <= in_range;
            if (in_range) ptr_q <= ptr_q + 16'd1;
          end
          default: resp_ack <= 1'b0;
        endcase
      end else if (state_q == ST_RDAT) begin
        if (rd_nak_in) begin
          state_q <= ST_DEAD;
        end else if (rd_fire) begin
          ptr_q <= ptr_q + 16'd1;
        end else if (rd_ready) begin
          resp_valid <= 1'b1;
          resp_ack   <= 1'b0;
          state_q    <= ST_DEAD;
        end
      end
    end
  end

  // R7
  store_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_en |-> !busy);

  // R10
  wr_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && !bus_start && !bus_stop && !hdr_valid) |=> resp_valid);

  // R3
  rd_ptr_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready && !rd_nak_in && !bus_start && !bus_stop && !hdr_valid && !wr_valid)
      |=> ptr_q == $past(ptr_q) + 16'd1);

  // R8
  busy_hdr_nak_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && busy && !bus_start && !bus_stop) |=> (resp_valid && !resp_ack));

  // R9
  rd_nak_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_nak_in && !bus_start && !bus_stop && !hdr_valid && !wr_valid) |=> !rd_valid);
endmodule

// File: rtl/memc_ser_mem.sv
module memc_ser_mem #(
  parameter int MEM_BYTES  = 1024,
  parameter int PAGE_BYTES = 64,
  parameter int PROG_LAT   = 200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_start,
  input  logic       bus_stop,
  input  logic       hdr_valid,
  input  logic       hdr_rw,
  input  logic       wr_valid,
  output logic       wr_ready,
  input  logic [7:0] wr_data,
  output logic       rd_valid,
  input  logic       rd_ready,
  output logic [7:0] rd_data,
  input  logic       rd_nak_in,
  output logic       resp_valid,
  output logic       resp_ack,
  output logic       stretch
);
  localparam int AW = $clog2(MEM_BYTES);

  logic          busy;
  logic          st_en;
  logic          launch;
  logic [AW-1:0] st_addr;
  logic [AW-1:0] rd_addr;

  memc_ctrl #(.MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .bus_start(bus_start), .bus_stop(bus_stop),
    .hdr_valid(hdr_valid), .hdr_rw(hdr_rw),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_nak_in(rd_nak_in),
    .resp_valid(resp_valid), .resp_ack(resp_ack), .stretch(stretch),
    .busy(busy), .st_en(st_en), .st_addr(st_addr),
    .launch(launch), .rd_addr(rd_addr)
  );

  memc_page #(.MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES), .PROG_LAT(PROG_LAT)) u_page (
    .clk(clk), .rst_n(rst_n),
    .st_en(st_en), .st_addr(st_addr), .st_data(wr_data),
    .launch(launch), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy)
  );
endmodule

// File: tb/memc_ser_mem_bench.sv
`timescale 1ns/1ps
module memc_ser_mem_bench;
  localparam int LAT = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_start = 1'b0, bus_stop = 1'b0, hdr_valid = 1'b0, hdr_rw = 1'b0;
  logic wr_valid = 1'b0, rd_ready = 1'b0, rd_nak_in = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic wr_ready, rd_valid, resp_valid, resp_ack, stretch;
  logic [7:0] rd_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  memc_ser_mem #(.MEM_BYTES(1024), .PAGE_BYTES(64), .PROG_LAT(LAT)) u_memc_ser_mem (
    .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
    .hdr_valid(hdr_valid), .hdr_rw(hdr_rw), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .rd_nak_in(rd_nak_in), .resp_valid(resp_valid), .resp_ack(resp_ack), .stretch(stretch)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) bus_start = 1'b1;
    @(negedge clk) bus_start = 1'b0;
  endtask

  task automatic pulse_stop();
    @(negedge clk) bus_stop = 1'b1;
    @(negedge clk) bus_stop = 1'b0;
  endtask

  task automatic send_hdr(input bit rw, input bit exp_ack, input string req);
    @(negedge clk) begin hdr_valid = 1'b1; hdr_rw = rw; end
    @(negedge clk) hdr_valid = 1'b0;
    chk(resp_valid && (resp_ack == exp_ack), req, {resp_valid, resp_ack}, {1'b1, exp_ack});
  endtask

  // Caller has wr_valid low or already at a negedge; leaves wr_valid high if keep.
  task automatic send_byte(input logic [7:0] d, input bit exp_ack, input bit keep,
                           input string req, output int held);
    held = 0;
    if (!wr_valid) @(negedge clk);
    wr_valid = 1'b1;
    wr_data  = d;
    while (!wr_ready) begin
      if (!stretch) chk(1'b0, "R7 stretch", 0, 1);
      held++;
      @(negedge clk);
    end
    @(negedge clk);
    if (!keep) wr_valid = 1'b0;
    chk(resp_valid && (resp_ack == exp_ack), req, {resp_valid, resp_ack}, {1'b1, exp_ack});
  endtask

  task automatic read_byte(input logic [7:0] exp, input string req);
    @(negedge clk) rd_ready = 1'b1;
    chk(rd_valid && (rd_data == exp), req, {rd_valid, rd_data}, {1'b1, exp});
    @(negedge clk) rd_ready = 1'b0;
  endtask

  task automatic master_nak();
    @(negedge clk) rd_nak_in = 1'b1;
    @(negedge clk) rd_nak_in = 1'b0;
    chk(!rd_valid, "R9 rd_valid after master NAK", rd_valid, 0);
  endtask

  task automatic set_ptr(input logic [15:0] p);
    int h;
    pulse_start();
    send_hdr(1'b0, 1'b1, "R2 write header");
    send_byte(p[15:8], 1'b1, 1'b0, "R2 high address byte", h);
    send_byte(p[7:0],  1'b1, 1'b0, "R2 low address byte", h);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!resp_valid && !stretch && !rd_valid && wr_ready, "R1 reset state",
        {resp_valid, stretch, rd_valid, wr_ready}, 4'b0001);
  endtask

  task automatic t_basic();
    int h;
    set_ptr(16'h0010);
    send_byte(8'hA1, 1'b1, 1'b0, "R5 data A1", h);
    send_byte(8'hA2, 1'b1, 1'b0, "R5 data A2", h);
    send_byte(8'hA3, 1'b1, 1'b0, "R5 data A3", h);
    pulse_stop();
    pulse_start();
    send_hdr(1'b1, 1'b0, "R8 header during program");
    send_byte(8'h55, 1'b0, 1'b0, "R8 byte after refused header", h);
    pulse_stop();
    repeat (LAT + 5) @(negedge clk);
    set_ptr(16'h0010);
    pulse_start();
    send_hdr(1'b1, 1'b1, "R4 read header after repeated start");
    read_byte(8'hA1, "R3 read A1");
    read_byte(8'hA2, "R3 read A2");
    master_nak();
    pulse_stop();
    pulse_start();
    send_hdr(1'b1, 1'b1, "R4 read header after stop");
    read_byte(8'hA3, "R9 pointer after last byte sent");
    master_nak();
    pulse_stop();
  endtask

  task automatic t_cross();
    int h;
    set_ptr(16'h003E);
    send_byte(8'h5A, 1'b1, 1'b1, "R7 byte at 3E", h);
    send_byte(8'h5B, 1'b1, 1'b1, "R7 byte at 3F", h);
    send_byte(8'h5C, 1'b1, 1'b1, "R7 held byte at 40", h);
    chk(h == LAT, "R7 stretch length", h, LAT);
    send_byte(8'h5D, 1'b1, 1'b0, "R7 byte at 41", h);
    chk(h == 0, "R7 no stretch inside page", h, 0);
    pulse_stop();
    repeat (LAT + 5) @(negedge clk);
    set_ptr(16'h003E);
    pulse_start();
    send_hdr(1'b1, 1'b1, "R3 read header");
    read_byte(8'h5A, "R7 readback 3E");
    read_byte(8'h5B, "R7 readback 3F");
    read_byte(8'h5C, "R7 readback 40");
    read_byte(8'h5D, "R7 readback 41");
    master_nak();
    pulse_stop();
  endtask

  task automatic t_range();
    int h;
    set_ptr(16'h03FF);
    send_byte(8'h77, 1'b1, 1'b0, "R5 byte at top", h);
    send_byte(8'h78, 1'b0, 1'b0, "R5 byte past top", h);
    pulse_stop();
    repeat (LAT + 5) @(negedge clk);
    pulse_start();
    send_hdr(1'b1, 1'b0, "R6 read header past top");
    pulse_stop();
    set_ptr(16'h8010);
    send_byte(8'hEE, 1'b0, 1'b0, "R5 high address bit set", h);
    pulse_stop();
    repeat (LAT + 5) @(negedge clk);
    set_ptr(16'h0010);
    pulse_start();
    send_hdr(1'b1, 1'b1, "R3 read header");
    read_byte(8'hA1, "R5 aliased location untouched");
    master_nak();
    pulse_stop();
    set_ptr(16'h03FF);
    pulse_start();
    send_hdr(1'b1, 1'b1, "R6 read header at top");
    read_byte(8'h77, "R6 read top byte");
    @(negedge clk) rd_ready = 1'b1;
    chk(!rd_valid, "R6 rd_valid past top", rd_valid, 0);
    @(negedge clk) rd_ready = 1'b0;
    chk(resp_valid && !resp_ack, "R6 refused read request", {resp_valid, resp_ack}, 2'b10);
    @(negedge clk);
    chk(!resp_valid, "R10 single-cycle decision", resp_valid, 0);
    pulse_stop();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_cross();
    t_range();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule